// File: doc/BRIEF.md
# Split Adder/Subtractor with Upper-Half Suppression

This block adds or subtracts two 16-bit two's-complement operands. The datapath is cut into a low segment (bits 7:0) and a high segment (bits 15:8). A detector examines the upper bits of both operands on every valid cycle. When each operand's bits 15:7 are all equal, the high half of the result is fully determined by the low segment's carry-out and the two low-segment sign bits. In that case the high-segment operand latches are frozen, so the high adder's inputs stop toggling. The high result then comes from a replicated fill bit rather than from the high adder.

For subtraction the B operand is inverted and the low-segment carry-in is forced to 1. Detection runs on the inverted B. Results are registered and appear one clock after the valid cycle, together with a registered flag that shows whether the high adder was bypassed.

Top module: `split_add_gate`

## Requirements
- R1: While reset is high and on the first cycle after it, `sum_out`, `valid_out` and `skip_out` are all 0.
- R2: A cycle with `valid_in`=1 and `sub_in`=0 yields, after the next rising edge, `sum_out` = (A + B) mod 2^16 with `valid_out`=1.
- R3: A cycle with `valid_in`=1 and `sub_in`=1 yields, after the next rising edge, `sum_out` = (A - B) mod 2^16.
- R4: After a valid cycle, `skip_out` is 1 exactly when bits 15:7 of A are all equal and bits 15:7 of the effective B (B, or ~B when subtracting) are all equal. Otherwise it is 0.
- R5: When `skip_out` is 1, `sum_out` is still exact for every sign mix: one negative and one positive operand, both negative, with or without a low-segment carry, and a carry ripple that leaves the high half unchanged. Bits 15:8 of `sum_out` all equal bit 8.
- R6: While the bypass is active on consecutive cycles, the high-segment operand latches hold their value.
- R7: A cycle with `valid_in`=0 makes `valid_out` 0 after the next edge and leaves `sum_out` and `skip_out` unchanged.
- R8: On a non-bypassed operation, the low-segment carry-out propagates into bit 8 (for example 0x00FF + 0x0001 = 0x0100).
- R9: Results wrap modulo 2^16 at the signed boundary (0x7FFF + 0x0001 = 0x8000, 0x8000 - 0x0001 = 0x7FFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Operand A, two's complement |
| b_in | input | 16 | Operand B, two's complement |
| sub_in | input | 1 | 1 selects A - B, 0 selects A + B |
| valid_in | input | 1 | Operands are present this cycle |
| sum_out | output | 16 | Registered result |
| valid_out | output | 1 | `sum_out` was updated by the previous valid cycle |
| skip_out | output | 1 | The high adder was bypassed for this result |

## Verification
The bypass decision and the low-segment carry-out meet in the same cycle: the fill bit that replaces the high half depends on a carry that is produced by the same low add. Directed operands force this collision in every sign class, both when the low carry is set and when it is clear, and also under subtraction, where the inverted B and the forced carry-in feed both the detector and the carry. A behavioural model in the bench computes the plain modulo-2^16 result and the expected bypass flag on every clock. It compares all three outputs, so any mistake in the fill or the carry glue shows up as a mismatch in the sum.

// File: rtl/split_add_pkg.sv
package split_add_pkg;

  // Controls produced by the detector for the high segment.
  typedef struct packed {
    logic close;      // freeze high-segment operand latches
    logic carry_blk;  // divert low carry away from the high adder
    logic sext_en;    // select the replicated fill as high result
    logic sign_pol;   // xor of the two low-segment sign bits
  } seg_ctrl_t;

endpackage

// File: rtl/split_detect.sv
module split_detect
  import split_add_pkg::*;
#(
  parameter int HW = 9   // bits inspected per operand (high segment plus top low bit)
) (
  input  logic          valid_in,
  input  logic [HW-1:0] a_top,
  input  logic [HW-1:0] b_top,
  output seg_ctrl_t     ctrl
);

  logic a_uniform;
  logic b_uniform;
  logic predict;

  // An operand is pure sign extension when the inspected bits are all 0 or all 1.
  assign a_uniform = (&a_top) | ~(|a_top);
  assign b_uniform = (&b_top) | ~(|b_top);
  assign predict   = valid_in & a_uniform & b_uniform;

  always_comb begin
    ctrl.close     = predict;
    ctrl.carry_blk = predict;
    ctrl.sext_en   = predict;
    // Lowest inspected bit is the sign bit of the low segment.
    ctrl.sign_pol  = predict & (a_top[0] ^ b_top[0]);
  end

endmodule

// File: rtl/split_hold_latch.sv
module split_hold_latch #(
  parameter int N = 8
) (
  input  logic         hold,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  // Transparent while hold is low, keeps its value while hold is high.
  always_latch begin
    if (!hold) q <= d;
  end

endmodule

// File: rtl/split_seg_adder.sv
module split_seg_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         ci,
  output logic [N-1:0] s,
  output logic         co
);

  logic [N:0] c;

  assign c[0] = ci;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      assign s[gi]   = a[gi] ^ b[gi] ^ c[gi];
      assign c[gi+1] = (a[gi] & b[gi]) | (c[gi] & (a[gi] ^ b[gi]));
    end
  endgenerate

  assign co = c[N];

endmodule

// File: rtl/split_add_gate.sv
module split_add_gate
  import split_add_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         sub_in,
  input  logic         valid_in,
  output logic [W-1:0] sum_out,
  output logic         valid_out,
  output logic         skip_out
);

  localparam int MW = W - LW;     // high segment width
  localparam int HW = MW + 1;     // bits examined per operand

  logic [W-1:0]  b_eff;
  seg_ctrl_t     ctrl;
  logic [LW-1:0] lo_sum;
  logic          lo_co;
  logic [MW-1:0] hi_a_l;
  logic [MW-1:0] hi_b_l;
  logic          hi_ci;
  logic [MW-1:0] hi_sum;
  logic          hi_co_unused;
  logic          fill;
  logic [MW-1:0] hi_res;

  // Subtraction: invert B, carry-in of 1 into the low segment.
  assign b_eff = sub_in ? ~b_in : b_in;

  split_detect #(.HW(HW)) u_detect (
    .valid_in (valid_in),
    .a_top    (a_in[W-1:LW-1]),
    .b_top    (b_eff[W-1:LW-1]),
    .ctrl     (ctrl)
  );

  split_seg_adder #(.N(LW)) u_lo_add (
    .a  (a_in[LW-1:0]),
    .b  (b_eff[LW-1:0]),
    .ci (sub_in),
    .s  (lo_sum),
    .co (lo_co)
  );

  split_hold_latch #(.N(MW)) u_hold_a (
    .hold (ctrl.close),
    .d    (a_in[W-1:LW]),
    .q    (hi_a_l)
  );

  split_hold_latch #(.N(MW)) u_hold_b (
    .hold (ctrl.close),
    .d    (b_eff[W-1:LW]),
    .q    (hi_b_l)
  );

  // Carry glue: the low carry feeds the high adder only when it is in use.
  assign hi_ci = ctrl.carry_blk ? 1'b0 : lo_co;

  split_seg_adder #(.N(MW)) u_hi_add (
    .a  (hi_a_l),
    .b  (hi_b_l),
    .ci (hi_ci),
    .s  (hi_sum),
    .co (hi_co_unused)
  );

  // Bit LW of the sign-extended low sum, replicated across the high half.
  assign fill   = ctrl.sign_pol ^ lo_co;
  assign hi_res = ctrl.sext_en ? {MW{fill}} : hi_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      valid_out <= 1'b0;
      skip_out  <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        sum_out  <= {hi_res, lo_sum};
        skip_out <= ctrl.close;
      end
    end
  end

  // ---------------- assertions ----------------
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (sum_out == '0 && !valid_out && !skip_out));

  a_r2_valid_pipe: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> (!valid_out && $stable(sum_out) && $stable(skip_out)));

  a_r5_fill_shape: assert property (@(posedge clk) disable iff (rst)
    (valid_out && skip_out) |-> (sum_out[W-1:LW] == {MW{sum_out[LW]}}));

  a_r4_no_skip_wide_a: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !(&a_in[W-1:LW-1]) && (|a_in[W-1:LW-1])) |=> !skip_out);

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ctrl.close && $past(ctrl.close)) |-> ($stable(hi_a_l) && $stable(hi_b_l)));

endmodule

// File: tb/test_split_add_gate.sv
module test_split_add_gate;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] a_in;
  logic [15:0] b_in;
  logic        sub_in;
  logic        valid_in;
  logic [15:0] sum_out;
  logic        valid_out;
  logic        skip_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  string cur_tag = "R1";

  // reference state
  logic [15:0] exp_sum   = '0;
  logic        exp_valid = 1'b0;
  logic        exp_skip  = 1'b0;
  string       exp_tag   = "R1";

  always #10 clk = ~clk;   // 50 MHz

  split_add_gate i_split_add_gate (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .b_in      (b_in),
    .sub_in    (sub_in),
    .valid_in  (valid_in),
    .sum_out   (sum_out),
    .valid_out (valid_out),
    .skip_out  (skip_out)
  );

  function automatic bit is_ext(input logic [15:0] x);
    return (x[15:7] == 9'h000) || (x[15:7] == 9'h1FF);
  endfunction

  // behavioural reference, sampled on the same edge as the design
  always @(posedge clk) begin
    if (rst) begin
      exp_sum   <= '0;
      exp_valid <= 1'b0;
      exp_skip  <= 1'b0;
      exp_tag   <= "R1";
    end else begin
      exp_valid <= valid_in;
      exp_tag   <= valid_in ? cur_tag : "R7";
      if (valid_in) begin
        exp_sum  <= sub_in ? (a_in - b_in) : (a_in + b_in);
        exp_skip <= is_ext(a_in) && is_ext(b_in);
      end
    end
  end

  task automatic check16(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (model_on && !done) begin
      check16(exp_tag, "sum_out",   sum_out,          exp_sum);
      check16(exp_tag, "valid_out", {15'd0, valid_out}, {15'd0, exp_valid});
      check16((exp_tag == "R2") ? "R4" : exp_tag, "skip_out",
              {15'd0, skip_out}, {15'd0, exp_skip});
    end
  end

  task automatic op(input logic [15:0] a, input logic [15:0] b,
                    input logic s, input string tag);
    @(negedge clk);
    a_in = a; b_in = b; sub_in = s; valid_in = 1'b1; cur_tag = tag;
  endtask

  task automatic idle(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    a_in = a; b_in = b; sub_in = 1'b0; valid_in = 1'b0; cur_tag = "R7";
  endtask

  initial begin
    rst = 1'b1; a_in = '0; b_in = '0; sub_in = 1'b0; valid_in = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check16("R1", "sum_out reset",   sum_out, 16'h0000);
    check16("R1", "valid_out reset", {15'd0, valid_out}, 16'h0000);
    check16("R1", "skip_out reset",  {15'd0, skip_out},  16'h0000);
    rst = 1'b0;
    model_on = 1'b1;

    // R5 sign classes with the bypass active
    op(16'hFFF0, 16'h0005, 1'b0, "R5");  // neg + pos, no low carry
    op(16'hFFF0, 16'h0020, 1'b0, "R5");  // neg + pos, low carry
    op(16'hFF90, 16'hFFF0, 1'b0, "R5");  // both negative
    op(16'hFF80, 16'hFF80, 1'b0, "R5");  // both at -128
    op(16'h0001, 16'hFFFF, 1'b0, "R5");  // ripple, high half unchanged
    op(16'h007F, 16'h007F, 1'b0, "R5");  // both positive at the edge
    // R2 plain adds
    op(16'h1234, 16'h0F0F, 1'b0, "R2");
    op(16'hA5A5, 16'h5A5A, 1'b0, "R2");
    // R8 carry into bit 8 without bypass
    op(16'h00FF, 16'h0001, 1'b0, "R8");
    op(16'h0180, 16'h0080, 1'b0, "R8");
    // R9 wrap
    op(16'h7FFF, 16'h0001, 1'b0, "R9");
    op(16'h8000, 16'h0001, 1'b1, "R9");
    // R3 subtraction, bypassed and not
    op(16'h0005, 16'h0009, 1'b1, "R3");
    op(16'h3000, 16'h1000, 1'b1, "R3");
    op(16'hFF80, 16'h007F, 1'b1, "R3");
    // R6 consecutive bypassed ops
    op(16'h0003, 16'h0004, 1'b0, "R6");
    op(16'hFFFE, 16'h0010, 1'b1, "R6");
    // R7 idle with changing operands
    idle(16'h4444, 16'h1111);
    idle(16'h0001, 16'h0001);
    op(16'h0100, 16'h0200, 1'b0, "R2");
    idle(16'hFFFF, 16'hFFFF);

    // random phase mixing small and wide operands
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ra, rb;
      ra = (($urandom % 2) == 0) ? 16'($signed(8'($urandom))) : 16'($urandom);
      rb = (($urandom % 2) == 0) ? 16'($signed(8'($urandom))) : 16'($urandom);
      if (($urandom % 5) == 0) idle(ra, rb);
      else op(ra, rb, 1'($urandom), "R2");
    end
    idle(16'h0, 16'h0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule